// File: doc/BRIEF.md
# BCD calendar counter chain

This block is the timekeeping core of a real-time clock. A 128 Hz strobe advances a 7-bit sub-second counter. Each time that counter wraps, a chain of packed-BCD fields moves forward by one second. The fields are seconds, minutes, hours, weekday, day of month, month, year within the century and century. Day-of-month rollover follows the month length, and February follows the Gregorian leap-year rule taken over the full four-digit year.

Software reaches every field through a byte-wide register port: a shared address, a write strobe with write data, and combinational read data. Two control registers select whether the chain counts and whether the sub-second prescaler is held at zero. They also hold a carry flag that software clears before it reads the time and checks afterwards. If the flag is set again, a second boundary fell inside the read and the read must be repeated. A one-cycle pulse marks every second advance for neighbouring logic. The carry flag, gated by an enable bit, drives an interrupt output.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the fields read seconds, minutes, hours, weekday and year-within-century 0x00, day 0x01, month 0x01, century 0x20, and both control registers read 0x00, so the chain is stopped.
- R2: Address 0 reads the sub-second count in bits 6:0, with bit 7 always 0. While running, each cycle with tick_128 high adds one, modulo 128. A tick taken when the count is 127 advances the seconds field at that clock edge. sec_pulse is high during exactly that cycle.
- R3: Counting requires control register 2 (address 15) bit 0 (start) and bit 3 (clock enable) both set. With either bit clear, ticks change neither the sub-second count nor any field.
- R4: While control register 2 bit 1 (prescaler reset) is set, the sub-second count is held at 0 and no second advance occurs.
- R5: Seconds and minutes roll from 0x59 to 0x00, hours roll from 0x23 to 0x00, and each roll carries into the next field.
- R6: The weekday (address 4) advances with every day change and rolls from 0x06 to 0x00.
- R7: The day of month (address 5) rolls to 0x01 after 0x30 in April, June, September and November, and after 0x31 in the other non-February months. The month (address 6) rolls from 0x12 to 0x01 and carries into the year.
- R8: February ends on 0x29 when the full year is divisible by 4. The exception is a year-within-century of 00, where the year is leap only if the century is divisible by 4. Otherwise February ends on 0x28.
- R9: The year within the century (address 7) rolls from 0x99 to 0x00 and increments the century (address 8). The century rolls from 0x99 to 0x00.
- R10: Control register 1 (address 14) bit 7 is the carry flag. Every second advance sets it. A write with bit 7 at 0 clears it, and a write with bit 7 at 1 leaves it unchanged. When a second advance coincides with a clearing write, the flag ends up set.
- R11: Control register 1 bit 4 is the carry interrupt enable, and carry_irq equals the carry flag AND this enable.
- R12: A write to addresses 1 to 8 is visible the next cycle whether or not the chain runs, and it overrides an increment of that field in the same cycle. Writes to address 0 are ignored.
- R13: Control register 1 reads only bits 7 and 4. Control register 2 reads only bits 3, 1 and 0, and the rest read 0. Addresses 9 to 13 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_128 | input | 1 | One-cycle strobe at 128 Hz |
| bus_addr | input | 4 | Register index for read and write |
| bus_wr | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| sec_pulse | output | 1 | High in the cycle whose clock edge advances the seconds |
| carry_irq | output | 1 | Carry flag gated by the carry interrupt enable |

## Verification
The bench targets the cascade boundaries: end of year across a century, the year 9999, month ends of 30 and 31 days, and February in an ordinary year, a leap year, a century year divisible by 400 and one that is not. A wrong month table or leap rule would show as a day of 0x29, 0x30 or 0x31 where 0x01 belongs, or the reverse. A missing century carry would show as year 00 with an unchanged century. The bench also aims a clearing write at the exact tick of a second advance. A design that let the clear win would lose the rollover the flag exists to report. The remaining checks cover stopped, half-enabled and prescaler-held states, where a design that ignored either control bit would move the sub-second count.

// File: rtl/rtc_cal_pkg.sv
// Package: shared constants and BCD helpers for the calendar counter chain.
// Assumes packed BCD bytes: upper nibble tens, lower nibble units.
package rtc_cal_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int NUM_FIELDS = 8;

    // Register indices the software side decodes.
    localparam logic [ADDR_W-1:0] ADR_SUBSEC = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_FIRST  = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_LAST   = 4'd8;
    localparam logic [ADDR_W-1:0] ADR_CTL1   = 4'd14;
    localparam logic [ADDR_W-1:0] ADR_CTL2   = 4'd15;

    // Control bit positions.
    localparam int CF_BIT    = 7;
    localparam int CIE_BIT   = 4;
    localparam int START_BIT = 0;
    localparam int PRST_BIT  = 1;
    localparam int CLKEN_BIT = 3;

    // Field slots in chain order.
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_WDAY = 3;
    localparam int F_DAY  = 4;
    localparam int F_MON  = 5;
    localparam int F_YLO  = 6;
    localparam int F_CENT = 7;

    // Next packed-BCD value of a byte.
    function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Binary value of a valid two-digit BCD byte.
    function automatic logic [6:0] bcd_to_bin(input logic [BYTE_W-1:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    // Lowest value a field rolls back to.
    function automatic logic [BYTE_W-1:0] field_min(input int slot);
        return (slot == F_DAY || slot == F_MON) ? 8'h01 : 8'h00;
    endfunction

    // Value a field takes at reset.
    function automatic logic [BYTE_W-1:0] field_rst(input int slot,
                                                    input logic [BYTE_W-1:0] cent);
        if (slot == F_CENT)
            return cent;
        return field_min(slot);
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Sub-second prescaler: counts run-qualified ticks and flags the wrap.
// Assumes tick is a one-cycle strobe; hold_clr has priority over counting.
module rtc_prescaler #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             hold_clr,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    // The tick that finds the counter full produces the one-second step.
    assign wrap = tick && run && !hold_clr && (cnt == {CNT_W{1'b1}});

    // Count ticks while running, hold at zero while cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (hold_clr)
            cnt <= '0;
        else if (tick && run)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/rtc_bcd_field.sv
// One packed-BCD calendar field with bus load and rollover.
// Assumes max_val is valid BCD; any value at or above it rolls to MIN_VAL,
// so an out-of-range software write recovers on the next increment.
module rtc_bcd_field
    import rtc_cal_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MIN_VAL = 8'h00,
    parameter logic [BYTE_W-1:0] RST_VAL = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic [BYTE_W-1:0] max_val,
    input  logic              ld,
    input  logic [BYTE_W-1:0] ld_val,
    output logic [BYTE_W-1:0] value
);

    // Load beats increment; increment rolls at the top of the range.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= RST_VAL;
        else if (ld)
            value <= ld_val;
        else if (inc)
            value <= (value >= max_val) ? MIN_VAL : bcd_inc(value);
    end

endmodule

// File: rtl/rtc_month_len.sv
// Last day of the current month in BCD, with the Gregorian leap rule
// applied to the four-digit year formed by century and year-in-century.
module rtc_month_len
    import rtc_cal_pkg::*;
(
    input  logic [BYTE_W-1:0] month,
    input  logic [BYTE_W-1:0] year_lo,
    input  logic [BYTE_W-1:0] century,
    output logic [BYTE_W-1:0] last_day
);

    logic [6:0] yl_bin;
    logic [6:0] cy_bin;
    logic       leap;

    assign yl_bin = bcd_to_bin(year_lo);
    assign cy_bin = bcd_to_bin(century);

    // Year 00 of a century is leap only when the century divides by 4.
    assign leap = (yl_bin == 7'd0) ? (cy_bin[1:0] == 2'b00) : (yl_bin[1:0] == 2'b00);

    // Month table.
    always_comb begin
        case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_calendar_core.sv
// Calendar counter chain top: prescaler, eight BCD fields, control
// registers and the byte register port.
// Assumes one synchronous clock; tick_128 is already in this domain.
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int                SUBSEC_W      = 7,
    parameter logic [BYTE_W-1:0] RESET_CENTURY = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_128,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              sec_pulse,
    output logic              carry_irq
);

    localparam int PAD_W = BYTE_W - SUBSEC_W;

    logic                carry_flag;
    logic                carry_ie;
    logic                start_bit;
    logic                clken_bit;
    logic                presc_rst;
    logic                run;
    logic [SUBSEC_W-1:0] subsec_cnt;
    logic                sec_adv;
    logic [BYTE_W-1:0]   day_last;
    logic                wr_ctl1;
    logic                wr_ctl2;
    logic [2:0]          fld_sel;

    logic [BYTE_W-1:0]     fld_val [NUM_FIELDS];
    logic [BYTE_W-1:0]     fld_max [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] fld_inc;
    logic [NUM_FIELDS-1:0] fld_ld;

    assign run     = start_bit && clken_bit;
    assign wr_ctl1 = bus_wr && (bus_addr == ADR_CTL1);
    assign wr_ctl2 = bus_wr && (bus_addr == ADR_CTL2);

    rtc_prescaler #(.CNT_W(SUBSEC_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_128),
        .run      (run),
        .hold_clr (presc_rst),
        .cnt      (subsec_cnt),
        .wrap     (sec_adv)
    );

    rtc_month_len u_mlen (
        .month    (fld_val[F_MON]),
        .year_lo  (fld_val[F_YLO]),
        .century  (fld_val[F_CENT]),
        .last_day (day_last)
    );

    // Upper bound of each field.
    always_comb begin
        fld_max[F_SEC]  = 8'h59;
        fld_max[F_MIN]  = 8'h59;
        fld_max[F_HOUR] = 8'h23;
        fld_max[F_WDAY] = 8'h06;
        fld_max[F_DAY]  = day_last;
        fld_max[F_MON]  = 8'h12;
        fld_max[F_YLO]  = 8'h99;
        fld_max[F_CENT] = 8'h99;
    end

    // Carry chain: a field steps when its predecessor steps from its top value.
    always_comb begin
        fld_inc[F_SEC]  = sec_adv;
        fld_inc[F_MIN]  = fld_inc[F_SEC]  && (fld_val[F_SEC]  >= fld_max[F_SEC]);
        fld_inc[F_HOUR] = fld_inc[F_MIN]  && (fld_val[F_MIN]  >= fld_max[F_MIN]);
        fld_inc[F_WDAY] = fld_inc[F_HOUR] && (fld_val[F_HOUR] >= fld_max[F_HOUR]);
        fld_inc[F_DAY]  = fld_inc[F_WDAY];
        fld_inc[F_MON]  = fld_inc[F_DAY]  && (fld_val[F_DAY]  >= fld_max[F_DAY]);
        fld_inc[F_YLO]  = fld_inc[F_MON]  && (fld_val[F_MON]  >= fld_max[F_MON]);
        fld_inc[F_CENT] = fld_inc[F_YLO]  && (fld_val[F_YLO]  >= fld_max[F_YLO]);
    end

    generate
        for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
            assign fld_ld[g] = bus_wr && (bus_addr == ADDR_W'(g + 1));

            rtc_bcd_field #(
                .MIN_VAL (field_min(g)),
                .RST_VAL (field_rst(g, RESET_CENTURY))
            ) u_field (
                .clk     (clk),
                .rst_n   (rst_n),
                .inc     (fld_inc[g]),
                .max_val (fld_max[g]),
                .ld      (fld_ld[g]),
                .ld_val  (bus_wdata),
                .value   (fld_val[g])
            );
        end
    endgenerate

    // Carry flag: set on every second step, set wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_flag <= 1'b0;
        else if (sec_adv)
            carry_flag <= 1'b1;
        else if (wr_ctl1 && !bus_wdata[CF_BIT])
            carry_flag <= 1'b0;
    end

    // Carry interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            carry_ie <= 1'b0;
        else if (wr_ctl1)
            carry_ie <= bus_wdata[CIE_BIT];
    end

    // Run controls and prescaler hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_bit <= 1'b0;
            clken_bit <= 1'b0;
            presc_rst <= 1'b0;
        end else if (wr_ctl2) begin
            start_bit <= bus_wdata[START_BIT];
            clken_bit <= bus_wdata[CLKEN_BIT];
            presc_rst <= bus_wdata[PRST_BIT];
        end
    end

    assign fld_sel = 3'(bus_addr - ADR_FIRST);

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_SUBSEC) begin
            bus_rdata = {{PAD_W{1'b0}}, subsec_cnt};
        end else if (bus_addr >= ADR_FIRST && bus_addr <= ADR_LAST) begin
            bus_rdata = fld_val[fld_sel];
        end else if (bus_addr == ADR_CTL1) begin
            bus_rdata[CF_BIT]  = carry_flag;
            bus_rdata[CIE_BIT] = carry_ie;
        end else if (bus_addr == ADR_CTL2) begin
            bus_rdata[START_BIT] = start_bit;
            bus_rdata[PRST_BIT]  = presc_rst;
            bus_rdata[CLKEN_BIT] = clken_bit;
        end
    end

    assign sec_pulse = sec_adv;
    assign carry_irq = carry_flag && carry_ie;

endmodule

// File: rtl/rtc_calendar_checker.sv
// Checker bound to the calendar core: temporal properties of the prescaler,
// the run controls, the seconds field and the carry flag.
module rtc_calendar_checker #(
    parameter int SUBSEC_W = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tick,
    input logic                run,
    input logic                presc_rst,
    input logic [SUBSEC_W-1:0] subsec,
    input logic                sec_pulse,
    input logic                cf,
    input logic [7:0]          sec_val,
    input logic                sec_wr
);

    AST_SUBSEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !presc_rst) |=> (subsec == $past(subsec) + 1'b1)); // R2

    AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        presc_rst |=> (subsec == '0)); // R4

    AST_STOPPED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !sec_wr) |=> $stable(sec_val)); // R3

    AST_SEC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !sec_wr) |=> (sec_val != $past(sec_val))); // R5

    AST_CARRY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> cf); // R10

endmodule

bind rtc_calendar_core rtc_calendar_checker #(.SUBSEC_W(SUBSEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick_128),
    .run       (run),
    .presc_rst (presc_rst),
    .subsec    (subsec_cnt),
    .sec_pulse (sec_pulse),
    .cf        (carry_flag),
    .sec_val   (fld_val[0]),
    .sec_wr    (fld_ld[0])
);

// File: tb/sim_rtc_calendar_core.sv
module sim_rtc_calendar_core;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wd = 8'd0;
    logic [7:0] rd;
    logic       spulse;
    logic       cirq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Behavioural reference state in plain integers.
    int m_sub, m_sec, m_min, m_hr, m_wd, m_day, m_mon, m_year;
    bit m_cf, m_cie, m_start, m_clken, m_prst;

    always #(CLK_P/2) clk = ~clk;

    rtc_calendar_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_128  (tick),
        .bus_addr  (addr),
        .bus_wr    (wr),
        .bus_wdata (wd),
        .bus_rdata (rd),
        .sec_pulse (spulse),
        .carry_irq (cirq)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(input int mon, input int year);
        bit leap;
        leap = ((year % 4 == 0) && (year % 100 != 0)) || (year % 400 == 0);
        case (mon)
            2:             return leap ? 29 : 28;
            4, 6, 9, 11:   return 30;
            default:       return 31;
        endcase
    endfunction

    function automatic logic [7:0] model_read(input logic [3:0] a);
        case (a)
            4'd0:  return 8'(m_sub);
            4'd1:  return to_bcd(m_sec);
            4'd2:  return to_bcd(m_min);
            4'd3:  return to_bcd(m_hr);
            4'd4:  return to_bcd(m_wd);
            4'd5:  return to_bcd(m_day);
            4'd6:  return to_bcd(m_mon);
            4'd7:  return to_bcd(m_year % 100);
            4'd8:  return to_bcd(m_year / 100);
            4'd14: return {m_cf, 2'b00, m_cie, 4'b0000};
            4'd15: return {4'b0000, m_clken, 1'b0, m_prst, m_start};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0:                   return "R2";
            4'd1, 4'd2, 4'd3:       return "R5";
            4'd4:                   return "R6";
            4'd5, 4'd6:             return "R7";
            4'd7, 4'd8:             return "R9";
            4'd14:                  return "R10";
            4'd15:                  return "R3";
            default:                return "R13";
        endcase
    endfunction

    // Reference model: one step per rising edge.
    always @(posedge clk) begin
        bit adv;
        if (!rst_n) begin
            m_sub = 0; m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0;
            m_day = 1; m_mon = 1; m_year = 2000;
            m_cf = 0; m_cie = 0; m_start = 0; m_clken = 0; m_prst = 0;
        end else begin
            adv = tick && m_start && m_clken && !m_prst && (m_sub == 127);
            if (m_prst) m_sub = 0;
            else if (tick && m_start && m_clken) m_sub = (m_sub + 1) % 128;
            if (adv) begin
                m_sec++;
                if (m_sec == 60) begin
                    m_sec = 0; m_min++;
                    if (m_min == 60) begin
                        m_min = 0; m_hr++;
                        if (m_hr == 24) begin
                            m_hr = 0; m_wd = (m_wd + 1) % 7; m_day++;
                            if (m_day > days_in(m_mon, m_year)) begin
                                m_day = 1; m_mon++;
                                if (m_mon == 13) begin
                                    m_mon = 1; m_year = (m_year + 1) % 10000;
                                end
                            end
                        end
                    end
                end
            end
            if (wr) begin
                case (addr)
                    4'd1:  m_sec  = from_bcd(wd);
                    4'd2:  m_min  = from_bcd(wd);
                    4'd3:  m_hr   = from_bcd(wd);
                    4'd4:  m_wd   = from_bcd(wd);
                    4'd5:  m_day  = from_bcd(wd);
                    4'd6:  m_mon  = from_bcd(wd);
                    4'd7:  m_year = (m_year / 100) * 100 + from_bcd(wd);
                    4'd8:  m_year = from_bcd(wd) * 100 + m_year % 100;
                    4'd14: m_cie  = wd[4];
                    4'd15: begin m_start = wd[0]; m_prst = wd[1]; m_clken = wd[3]; end
                    default: ;
                endcase
            end
            if (adv) m_cf = 1;
            else if (wr && addr == 4'd14 && !wd[7]) m_cf = 0;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, then compare outputs.
    task automatic step(input bit t, input bit w, input logic [3:0] a, input logic [7:0] d);
        bit exp_p;
        @(negedge clk);
        tick = t; wr = w; addr = a; wd = d;
        #1;
        exp_p = t && m_start && m_clken && !m_prst && (m_sub == 127);
        check(tag_of(a), rd, model_read(a));
        check("R2", 8'(spulse), 8'(exp_p));
        check("R11", 8'(cirq), 8'(m_cf && m_cie));
    endtask

    task automatic wreg(input logic [3:0] a, input logic [7:0] d);
        step(0, 1, a, d);
    endtask

    // Read a register and also compare against a value fixed by the requirements.
    task automatic expect_reg(input logic [3:0] a, input logic [7:0] exp, input string tag);
        step(0, 0, a, 8'h00);
        check(tag, rd, exp);
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            int k = i % 11;
            step(1, 0, (k < 9) ? 4'(k) : ((k == 9) ? 4'd14 : 4'd15), 8'h00);
        end
    endtask

    // Load a date at 23:59:59, align the prescaler, roll one second.
    task automatic roll_day(input logic [7:0] cen, input logic [7:0] yy,
                            input logic [7:0] mo, input logic [7:0] dy);
        wreg(4'd15, 8'h0B);
        wreg(4'd8, cen); wreg(4'd7, yy); wreg(4'd6, mo); wreg(4'd5, dy);
        wreg(4'd3, 8'h23); wreg(4'd2, 8'h59); wreg(4'd1, 8'h59);
        wreg(4'd15, 8'h09);
        run_ticks(128);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset contents
        expect_reg(4'd1, 8'h00, "R1"); expect_reg(4'd3, 8'h00, "R1");
        expect_reg(4'd5, 8'h01, "R1"); expect_reg(4'd6, 8'h01, "R1");
        expect_reg(4'd7, 8'h00, "R1"); expect_reg(4'd8, 8'h20, "R1");
        expect_reg(4'd14, 8'h00, "R1"); expect_reg(4'd15, 8'h00, "R1");

        // R12: writes while stopped, address 0 is read-only
        wreg(4'd0, 8'h55); expect_reg(4'd0, 8'h00, "R12");
        wreg(4'd1, 8'h42); expect_reg(4'd1, 8'h42, "R12");
        // R13: unmapped and reserved bits
        expect_reg(4'd10, 8'h00, "R13");
        wreg(4'd15, 8'hFF); expect_reg(4'd15, 8'h0B, "R13");
        wreg(4'd14, 8'h6F); expect_reg(4'd14, 8'h00, "R13");

        // R3: half-enabled chain does not count
        wreg(4'd15, 8'h01); run_ticks(5); expect_reg(4'd0, 8'h00, "R3");
        wreg(4'd15, 8'h08); run_ticks(5); expect_reg(4'd0, 8'h00, "R3");
        // R4: prescaler hold
        wreg(4'd15, 8'h0B); run_ticks(5); expect_reg(4'd0, 8'h00, "R4");
        wreg(4'd15, 8'h09);
        for (int i = 0; i < 3; i++) step(1, 0, 4'd0, 8'h00);
        expect_reg(4'd0, 8'h03, "R2");

        // R9, R6, R5: end of year across a century
        wreg(4'd4, 8'h06);
        roll_day(8'h19, 8'h99, 8'h12, 8'h31);
        expect_reg(4'd1, 8'h00, "R5"); expect_reg(4'd3, 8'h00, "R5");
        expect_reg(4'd4, 8'h00, "R6"); expect_reg(4'd5, 8'h01, "R7");
        expect_reg(4'd6, 8'h01, "R7"); expect_reg(4'd7, 8'h00, "R9");
        expect_reg(4'd8, 8'h20, "R9"); expect_reg(4'd14, 8'h80, "R10");

        // R11: enable, keep-on-1, clear-on-0
        wreg(4'd14, 8'h90); expect_reg(4'd14, 8'h90, "R11");
        check("R11", 8'(cirq), 8'h01);
        wreg(4'd14, 8'h10); expect_reg(4'd14, 8'h10, "R10");
        check("R11", 8'(cirq), 8'h00);

        // R10: clearing write on the exact advancing tick, set wins
        wreg(4'd15, 8'h0B); wreg(4'd15, 8'h09);
        run_ticks(127);
        step(1, 1, 4'd14, 8'h10);
        expect_reg(4'd14, 8'h90, "R10");

        // R12: write while running
        wreg(4'd2, 8'h33); expect_reg(4'd2, 8'h33, "R12");

        // R5: minute carry into hour
        wreg(4'd15, 8'h0B); wreg(4'd3, 8'h10); wreg(4'd2, 8'h59); wreg(4'd1, 8'h59);
        wreg(4'd15, 8'h09); run_ticks(128);
        expect_reg(4'd3, 8'h11, "R5"); expect_reg(4'd2, 8'h00, "R5");

        // R8: February cases
        roll_day(8'h20, 8'h24, 8'h02, 8'h28); expect_reg(4'd5, 8'h29, "R8");
        roll_day(8'h20, 8'h24, 8'h02, 8'h29); expect_reg(4'd5, 8'h01, "R8");
        expect_reg(4'd6, 8'h03, "R8");
        roll_day(8'h21, 8'h00, 8'h02, 8'h28); expect_reg(4'd5, 8'h01, "R8");
        roll_day(8'h20, 8'h00, 8'h02, 8'h28); expect_reg(4'd5, 8'h29, "R8");
        roll_day(8'h20, 8'h23, 8'h02, 8'h28); expect_reg(4'd6, 8'h03, "R8");

        // R7: 30- and 31-day months
        roll_day(8'h20, 8'h23, 8'h04, 8'h30); expect_reg(4'd5, 8'h01, "R7");
        expect_reg(4'd6, 8'h05, "R7");
        roll_day(8'h20, 8'h23, 8'h01, 8'h30); expect_reg(4'd5, 8'h31, "R7");
        roll_day(8'h20, 8'h23, 8'h01, 8'h31); expect_reg(4'd6, 8'h02, "R7");

        // R9: century wraps after 9999
        roll_day(8'h99, 8'h99, 8'h12, 8'h31);
        expect_reg(4'd8, 8'h00, "R9"); expect_reg(4'd7, 8'h00, "R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule